// File: doc/BRIEF.md
# Synchronous Block-Read Bus Controller

This controller sits on a 64-bit synchronous bus and fetches a block of 32-bit words from a memory. A requester supplies a start word address and a block length. The controller then puts the address on the bus for exactly one cycle and waits out the memory's first-group latency. After that it streams the block back as 64-bit beats, two words per beat, without releasing the bus and without sending the address again.

The memory delivers words in groups of four. The first group is ready a fixed number of cycles after the address cycle. Each later group is ready a shorter fixed number of cycles after the one before it. Each group is sent as two beats followed by two idle cycles, and that sending window overlaps the read of the next group. The bus therefore sees a fixed, predictable cycle count for every legal block length. That is 45 cycles for a 4-word block and 57 cycles for a 16-word block, counted from the address cycle through the last idle cycle.

The controller raises a one-cycle completion pulse after the final idle cycle. A length that is not a legal multiple of four is refused with a one-cycle error flag, and no bus activity follows.

Top module: `blkrd_engine`

## Requirements
- R1: After reset, `busy`, `busAddrValid`, `beatValid`, `done` and `reqErr` are all low.
- R2: A legal request sampled while idle drives `busAddrValid` high for exactly one cycle, in the cycle after the request, with `busAddr` equal to the requested start word address. No second address cycle occurs within the block.
- R3: A request length is legal only if it is a multiple of four and lies in the range 4 to 16 words. An illegal length raises `reqErr` for exactly one cycle, in the cycle after the request, and produces no address cycle, no beats and no busy period.
- R4: Counting the address cycle as cycle 1, the first beat appears in cycle FIRST_LAT + 2 (cycle 42 with the defaults).
- R5: Each group of four words is sent as exactly two consecutive beat cycles. During the beat with index k, counted from 0, `memRdAddr` equals start + 2k and `beatData` equals `memRdData`, with the lower-addressed word in bits 31:0.
- R6: The first beat of each later group comes max(LATER_LAT, 4) cycles after the first beat of the group before it (4 cycles with the defaults).
- R7: Two idle cycles follow the last beat. `done` is then high for one cycle, and `busy` falls with it. This makes 45 bus cycles for a 4-word block and 57 for a 16-word block.
- R8: A request presented while the controller is busy is ignored. It produces no further address cycle and does not shift the timing of the block in progress.
- R9: A block of N words produces exactly N/2 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqAddr | input | ADDR_W | Start word address |
| reqLen | input | LEN_W | Block length in 32-bit words |
| busy | output | 1 | A block is in progress (address cycle through done) |
| reqErr | output | 1 | One-cycle flag for an illegal length |
| busAddrValid | output | 1 | Address cycle on the bus |
| busAddr | output | ADDR_W | Address driven during the address cycle |
| memRdAddr | output | ADDR_W | Word address of the current beat's lower word |
| memRdData | input | BUS_W | Two words read from memory at `memRdAddr` |
| beatValid | output | 1 | Data beat strobe |
| beatData | output | BUS_W | Beat payload, zero outside beats |
| done | output | 1 | One-cycle completion pulse |

## Verification
Counting the address cycle as cycle 1, the bench samples every output at the falling edge of every cycle. It predicts the exact cycle of each event from the parameters: the address in cycle 1, beat pairs starting at cycle FIRST_LAT + 2 and repeating every group period, and `done` one cycle after the two trailing idle cycles. It then compares each cycle's outputs against that prediction rather than waiting for an event to occur. Error flags are checked in cycle 1 and cycle 2 after an illegal request, followed by a quiet window longer than a full block. A request injected mid-block is checked to leave the predicted schedule unchanged.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_BEAT,
    ST_GAP,
    ST_TAIL,
    ST_DONE
  } blkrdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic beatAdv;
  } blkrdStrobe_t;

endpackage

// File: rtl/blkrd_ctrl.sv
module blkrd_ctrl
  import blkrd_pkg::*;
#(
  parameter int FIRST_LAT   = 40,
  parameter int LATER_LAT   = 4,
  parameter int IDLE_GAP    = 2,
  parameter int BUS_W       = 64,
  parameter int WORD_W      = 32,
  parameter int GROUP_WORDS = 4,
  parameter int MAX_WORDS   = 16,
  parameter int LEN_W       = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  output logic             busy,
  output logic             reqErr,
  output logic             busAddrValid,
  output logic             beatValid,
  output logic             done,
  output blkrdStrobe_t     strobe
);

  localparam int WORDS_PER_BEAT = BUS_W / WORD_W;
  localparam int BEATS_PER_GRP  = GROUP_WORDS / WORDS_PER_BEAT;
  localparam int SEND_WINDOW    = BEATS_PER_GRP + IDLE_GAP;
  localparam int GRP_PERIOD     = (LATER_LAT > SEND_WINDOW) ? LATER_LAT : SEND_WINDOW;
  localparam int CNT_W          = $clog2(FIRST_LAT + GRP_PERIOD + IDLE_GAP + 1);

  blkrdState_t        state;
  logic [CNT_W-1:0]   cnt;
  logic [LEN_W-1:0]   grpLeft;
  logic               lenOk;

  always_comb begin
    lenOk = (reqLen % LEN_W'(GROUP_WORDS) == '0) &&
            (reqLen >= LEN_W'(GROUP_WORDS)) &&
            (reqLen <= LEN_W'(MAX_WORDS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      grpLeft <= '0;
      reqErr  <= 1'b0;
    end else begin
      reqErr <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (lenOk) begin
              state   <= ST_ADDR;
              grpLeft <= reqLen / LEN_W'(GROUP_WORDS);
            end else begin
              reqErr <= 1'b1;
            end
          end
        end
        ST_ADDR: begin
          state <= ST_WAIT;
          cnt   <= CNT_W'(FIRST_LAT - 1);
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            state <= ST_BEAT;
            cnt   <= CNT_W'(BEATS_PER_GRP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_BEAT: begin
          if (cnt == '0) begin
            grpLeft <= grpLeft - 1'b1;
            if (grpLeft == LEN_W'(1)) begin
              state <= ST_TAIL;
              cnt   <= CNT_W'(IDLE_GAP - 1);
            end else begin
              state <= ST_GAP;
              cnt   <= CNT_W'(GRP_PERIOD - BEATS_PER_GRP - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == '0) begin
            state <= ST_BEAT;
            cnt   <= CNT_W'(BEATS_PER_GRP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TAIL: begin
          if (cnt == '0) state <= ST_DONE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy           = (state != ST_IDLE);
    busAddrValid   = (state == ST_ADDR);
    beatValid      = (state == ST_BEAT);
    done           = (state == ST_DONE);
    strobe.loadReq = (state == ST_IDLE) && reqValid && lenOk;
    strobe.beatAdv = (state == ST_BEAT);
  end

  // R2: address never held for two cycles
  p_addr_once_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAddrValid |=> !busAddrValid);

  // R5: beats arrive in pairs
  p_beat_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(beatValid) |=> beatValid);

  // R5: never three beats in a row
  p_beat_max_r5: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && $past(beatValid)) |=> !beatValid);

  // R7: done is a single pulse ending the busy period
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R3: an error flag never accompanies a started transfer
  p_err_nostart_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> !busy);

endmodule

// File: rtl/blkrd_datapath.sv
module blkrd_datapath
  import blkrd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  blkrdStrobe_t      strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  memRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [BUS_W-1:0]  beatData
);

  localparam int WORDS_PER_BEAT = BUS_W / WORD_W;

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      rdPtr   <= '0;
    end else if (strobe.loadReq) begin
      addrReg <= reqAddr;
      rdPtr   <= reqAddr;
    end else if (strobe.beatAdv) begin
      rdPtr <= rdPtr + ADDR_W'(WORDS_PER_BEAT);
    end
  end

  always_comb begin
    busAddr   = addrReg;
    memRdAddr = rdPtr;
    beatData  = strobe.beatAdv ? memRdData : '0;
  end

  // R5: read pointer steps by one beat's worth of words
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beatAdv |=> (rdPtr == $past(rdPtr) + ADDR_W'(WORDS_PER_BEAT)));

  // R2: captured address holds until the next accepted request
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadReq |=> $stable(addrReg));

endmodule

// File: rtl/blkrd_engine.sv
module blkrd_engine
  import blkrd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BUS_W       = 64,
  parameter int WORD_W      = 32,
  parameter int GROUP_WORDS = 4,
  parameter int MAX_WORDS   = 16,
  parameter int FIRST_LAT   = 40,
  parameter int LATER_LAT   = 4,
  parameter int IDLE_GAP    = 2,
  parameter int LEN_W       = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              reqErr,
  output logic              busAddrValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [BUS_W-1:0]  memRdData,
  output logic              beatValid,
  output logic [BUS_W-1:0]  beatData,
  output logic              done
);

  blkrdStrobe_t strobe;

  blkrd_ctrl #(
    .FIRST_LAT  (FIRST_LAT),
    .LATER_LAT  (LATER_LAT),
    .IDLE_GAP   (IDLE_GAP),
    .BUS_W      (BUS_W),
    .WORD_W     (WORD_W),
    .GROUP_WORDS(GROUP_WORDS),
    .MAX_WORDS  (MAX_WORDS),
    .LEN_W      (LEN_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqLen      (reqLen),
    .busy        (busy),
    .reqErr      (reqErr),
    .busAddrValid(busAddrValid),
    .beatValid   (beatValid),
    .done        (done),
    .strobe      (strobe)
  );

  blkrd_datapath #(
    .ADDR_W(ADDR_W),
    .BUS_W (BUS_W),
    .WORD_W(WORD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .memRdData(memRdData),
    .busAddr  (busAddr),
    .memRdAddr(memRdAddr),
    .beatData (beatData)
  );

endmodule

// File: tb/blkrd_engine_bench.sv
`timescale 1ns/1ps
module blkrd_engine_bench;

  localparam int AW      = 32;
  localparam int BW      = 64;
  localparam int LW      = 5;
  localparam int L0      = 40;
  localparam int L1      = 4;
  localparam int PERIOD  = (L1 > 4) ? L1 : 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic          busy, reqErr, busAddrValid, beatValid, done;
  logic [AW-1:0] busAddr, memRdAddr;
  logic [BW-1:0] memRdData, beatData;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  function automatic logic [BW-1:0] memWord(input logic [AW-1:0] a);
    return {(a + 32'd1) ^ 32'hA5A5_0000, a ^ 32'h0000_5A5A};
  endfunction

  assign memRdData = memWord(memRdAddr);

  blkrd_engine u_blkrd_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .busy(busy), .reqErr(reqErr),
    .busAddrValid(busAddrValid), .busAddr(busAddr), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .beatValid(beatValid), .beatData(beatData),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic testReset();
    chk(!busy && !busAddrValid && !beatValid && !done && !reqErr, "R1 reset outputs",
        {busy, busAddrValid, beatValid, done, reqErr}, 0);
  endtask

  // one legal block; inject=1 presents a second request mid-block (R8)
  task automatic testBlock(input logic [AW-1:0] addr, input int len, input bit inject);
    int grp = len / 4;
    int doneExp = 1 + L0 + (grp - 1) * PERIOD + 4 + 1;
    int addrCnt = 0, addrBad = 0, beatCnt = 0, posErr = 0, dataErr = 0;
    int firstBeat = -1, doneCyc = -1, doneCnt = 0, errCnt = 0, busyBad = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqLen = LW'(len);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 1; n <= doneExp + 3; n++) begin
      int off = n - (L0 + 2);
      bit beatExp = (off >= 0) && (off / PERIOD < grp) && (off % PERIOD < 2);
      if (busAddrValid) begin
        addrCnt++;
        if (n != 1 || busAddr != addr) addrBad++;
      end
      if (beatValid != beatExp) posErr++;
      if (beatValid) begin
        logic [AW-1:0] wa = addr + AW'(2 * beatCnt);
        if (firstBeat < 0) firstBeat = n;
        if (memRdAddr != wa || beatData != memWord(wa)) dataErr++;
        beatCnt++;
      end
      if (done) begin
        doneCnt++;
        if (doneCyc < 0) doneCyc = n;
      end
      if (reqErr) errCnt++;
      if (busy != (n <= doneExp)) busyBad++;
      if (inject && n == 10) begin
        reqValid = 1'b1; reqAddr = addr + 32'h100; reqLen = LW'(4);
      end
      if (inject && n == 11) reqValid = 1'b0;
      @(negedge clk);
    end
    chk(addrCnt == 1 && addrBad == 0, "R2 single address cycle with start address", addrCnt, 1);
    chk(firstBeat == L0 + 2, "R4 first beat cycle", firstBeat, L0 + 2);
    chk(posErr == 0, "R6 beat schedule mismatches", posErr, 0);
    chk(dataErr == 0, "R5 beat address/data mismatches", dataErr, 0);
    chk(beatCnt == len / 2, "R9 beat count", beatCnt, len / 2);
    chk(doneCyc == doneExp && doneCnt == 1, "R7 done cycle", doneCyc, doneExp);
    chk(busyBad == 0, "R7 busy window mismatches", busyBad, 0);
    chk(errCnt == 0, "R3 no error on legal length", errCnt, 0);
    if (inject) chk(addrCnt == 1 && doneCyc == doneExp, "R8 busy request ignored", doneCyc, doneExp);
  endtask

  task automatic testBadLen(input int len);
    int act = 0, errFirst, errSecond;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h40; reqLen = LW'(len);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    errFirst = reqErr;
    @(negedge clk);
    errSecond = reqErr;
    for (int n = 0; n < 70; n++) begin
      if (busy || busAddrValid || beatValid || done) act++;
      @(negedge clk);
    end
    chk(errFirst == 1, "R3 error flag raised", errFirst, 1);
    chk(errSecond == 0, "R3 error flag one cycle", errSecond, 0);
    chk(act == 0, "R3 no transfer after illegal length", act, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBlock(32'h0000_1000, 4, 1'b0);
    testBlock(32'h0000_2008, 8, 1'b0);
    testBlock(32'h0000_3010, 12, 1'b0);
    testBlock(32'hFFFF_FFF8, 16, 1'b0);
    testBlock(32'h0000_0020, 16, 1'b1);
    testBadLen(0);
    testBadLen(3);
    testBadLen(6);
    testBadLen(20);
    testBlock(32'h0000_5000, 4, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule